// File: doc/BRIEF.md
# Two-Channel Power Cell Split Controller

This block decides, one cell at a time, how a row of identical power cells is shared between two supply channels. Each channel runs from its own switching clock. A channel that runs faster is taken to be the more heavily loaded one. The controller counts the rising edges of both channel clocks over a fixed window of sampling-clock cycles. It then moves the split point one cell toward the faster channel, or it leaves the split point where it is when the two counts lie close enough together.

The allocation is a thermometer-coded vector with one bit per cell. Ones fill the vector from bit 0 upward and mark cells given to channel 1. Zeros mark cells given to channel 2. Because the split point moves by a single cell per decision, a cell is only ever handed over from one neighbour of the boundary to the other. A stop flag shows when the split has settled. The controller keeps measuring after it settles, so a later change in load restarts the shifting.

Top module: `cell_split_ctrl`

## Requirements
- R1: While reset is high and just after it falls, `cell_sel` holds ones in its lowest N_CELLS/2 bits and zeros above them. `dir`, `stop` and `ready` are 0.
- R2: `cell_sel` always has the form of a run of ones starting at bit 0 with zeros above the run. It changes by exactly one bit whenever it changes.
- R3: Each count is taken on rising edges of a channel clock after a two-flop synchronizer. If the channel-1 count exceeds the channel-2 count by more than HYST, the decision sets the lowest zero bit of `cell_sel` and drives `dir` to 0. If the channel-2 count exceeds the channel-1 count by more than HYST, the decision clears the highest one bit and drives `dir` to 1.
- R4: With `en` high, each cycle of operation runs WIN_CYCLES measuring cycles, then one cycle with `ready` high, then one clearing cycle. Rising edges of `ready` are therefore WIN_CYCLES+2 cycles apart. `cell_sel`, `dir` and `stop` change only on the clock edge that ends the `ready` cycle.
- R5: If the two counts differ by HYST or less, the decision sets `stop` to 1 and leaves both `cell_sel` and `dir` unchanged.
- R6: If a later window has counts that differ by more than HYST, `stop` returns to 0 and shifting resumes as in R3.
- R7: Bit 0 of `cell_sel` is always 1 and bit N_CELLS-1 is always 0. A decision that would push the boundary past either end leaves `cell_sel` unchanged, still drives `dir` as in R3, and sets `stop` to 0.
- R8: Each edge count saturates at 2^EDGE_W-1 and does not wrap. When both counts saturate, the decision acts as in R5.
- R9: While `en` is low, `ready` stays 0, `cell_sel`, `dir` and `stop` hold their values, and the edge counts are kept cleared. After `en` rises, the first `ready` comes WIN_CYCLES+1 cycles later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_s | input | 1 | Sampling clock for all logic |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Runs the measure and decide sequence when high |
| ch1_clk | input | 1 | Switching clock of channel 1, asynchronous to clk_s |
| ch2_clk | input | 1 | Switching clock of channel 2, asynchronous to clk_s |
| cell_sel | output | N_CELLS | Per-cell assignment: 1 gives the cell to channel 1, 0 gives it to channel 2 |
| dir | output | 1 | Last shift direction: 0 gives channel 1 a cell, 1 gives channel 2 a cell |
| stop | output | 1 | High when the last decision found the counts within HYST |
| ready | output | 1 | One-cycle pulse marking the decision cycle |

## Verification
The main instance has 16 cells, a 720-cycle window, 8-bit counts and a band of 4. With these values both ends of the vector are reached within a few decisions. The same instance also runs against a load model in which each channel's clock period grows with the number of cells it holds, so the controller has a balance point to converge to. A second instance has 8 cells, a 64-cycle window, 4-bit counts and a band of 1. It is driven with clocks that give more than 15 edges per window, so both counts saturate, and a counter that wrapped would cause a visible shift instead of a stop.

// File: rtl/cellsplit_pkg.sv
package cellsplit_pkg;

   typedef enum logic [1:0] {
      PH_CLEAR  = 2'd0,
      PH_MEAS   = 2'd1,
      PH_DECIDE = 2'd2
   } phase_t;

   typedef enum logic [1:0] {
      ACT_HOLD   = 2'd0,
      ACT_GROW   = 2'd1,
      ACT_SHRINK = 2'd2
   } action_t;

endpackage

// File: rtl/cs_edge_counter.sv
module cs_edge_counter #(
   parameter int EDGE_W      = 10,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              async_in,
   input  logic              cnt_en,
   input  logic              clr,
   output logic [EDGE_W-1:0] count
);

   localparam logic [EDGE_W-1:0] CNT_MAX = '1;

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   last_q;
   logic                   rise;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("cs_edge_counter: SYNC_STAGES must be at least 2");
      end
      if (EDGE_W < 2) begin : g_bad_width
         $error("cs_edge_counter: EDGE_W must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         sync_q <= '0;
         last_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], async_in};
         last_q <= sync_q[SYNC_STAGES-1];
      end
   end

   assign rise = sync_q[SYNC_STAGES-1] & ~last_q;

   always_ff @(posedge clk) begin
      if (rst || clr) begin
         count <= '0;
      end else if (cnt_en && rise && (count != CNT_MAX)) begin
         count <= count + 1'b1;
      end
   end

   // R8: a saturated count stays at its ceiling until cleared
   p_cnt_sat_r8: assert property (@(posedge clk) disable iff (rst)
      (count == CNT_MAX && !clr) |=> (count == CNT_MAX));

   // R8: without a clear the count never decreases and never jumps by more than one
   p_cnt_step_r8: assert property (@(posedge clk) disable iff (rst)
      (!clr) |=> (count == $past(count) || count == $past(count) + 1'b1));

   // R4: the clearing cycle empties the count
   p_cnt_clear_r4: assert property (@(posedge clk) disable iff (rst)
      clr |=> (count == '0));

endmodule

// File: rtl/cs_window_seq.sv
module cs_window_seq
   import cellsplit_pkg::*;
#(
   parameter int WIN_CYCLES = 1024
) (
   input  logic clk,
   input  logic rst,
   input  logic en,
   output logic meas,
   output logic decide,
   output logic clearing
);

   localparam int WIN_W = (WIN_CYCLES > 2) ? $clog2(WIN_CYCLES) : 1;
   localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WIN_CYCLES - 1);

   phase_t           ph_q;
   logic [WIN_W-1:0] win_q;

   generate
      if (WIN_CYCLES < 2) begin : g_bad_win
         $error("cs_window_seq: WIN_CYCLES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         ph_q  <= PH_CLEAR;
         win_q <= '0;
      end else if (!en) begin
         ph_q  <= PH_CLEAR;
         win_q <= '0;
      end else begin
         case (ph_q)
            PH_CLEAR: begin
               ph_q  <= PH_MEAS;
               win_q <= '0;
            end
            PH_MEAS: begin
               if (win_q == WIN_LAST) begin
                  ph_q <= PH_DECIDE;
               end else begin
                  win_q <= win_q + 1'b1;
               end
            end
            PH_DECIDE: begin
               ph_q <= PH_CLEAR;
            end
            default: begin
               ph_q  <= PH_CLEAR;
               win_q <= '0;
            end
         endcase
      end
   end

   assign meas     = (ph_q == PH_MEAS);
   assign decide   = (ph_q == PH_DECIDE);
   assign clearing = (ph_q == PH_CLEAR);

   // R4: the decision cycle lasts one cycle and is followed by a clearing cycle
   p_decide_pulse_r4: assert property (@(posedge clk) disable iff (rst)
      decide |=> (!decide && clearing));

   // R4: a decision is entered only from a measuring window
   p_decide_after_meas_r4: assert property (@(posedge clk) disable iff (rst)
      $rose(decide) |-> $past(meas));

   // R9: with enable low the sequencer parks in the clearing phase
   p_park_r9: assert property (@(posedge clk) disable iff (rst)
      (!en) |=> clearing);

endmodule

// File: rtl/cs_rate_compare.sv
module cs_rate_compare
   import cellsplit_pkg::*;
#(
   parameter int EDGE_W = 10,
   parameter int HYST   = 2
) (
   input  logic [EDGE_W-1:0] cnt_a,
   input  logic [EDGE_W-1:0] cnt_b,
   output action_t           action
);

   logic              a_ahead;
   logic [EDGE_W-1:0] gap;
   logic              in_band;

   generate
      if (HYST < 0 || HYST >= (1 << EDGE_W)) begin : g_bad_hyst
         $error("cs_rate_compare: HYST must lie in 0 .. 2**EDGE_W-1");
      end
   endgenerate

   always_comb begin
      a_ahead = (cnt_a > cnt_b);
      gap     = a_ahead ? (cnt_a - cnt_b) : (cnt_b - cnt_a);
   end

   generate
      if (HYST == 0) begin : g_exact
         assign in_band = (gap == '0);
      end else begin : g_band
         assign in_band = (gap <= EDGE_W'(HYST));
      end
   endgenerate

   always_comb begin
      if (in_band) begin
         action = ACT_HOLD;
      end else if (a_ahead) begin
         action = ACT_GROW;
      end else begin
         action = ACT_SHRINK;
      end
   end

endmodule

// File: rtl/cs_boundary_reg.sv
module cs_boundary_reg
   import cellsplit_pkg::*;
#(
   parameter int N_CELLS = 82
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               apply,
   input  action_t            action,
   output logic [N_CELLS-1:0] sel,
   output logic               dir,
   output logic               stop
);

   localparam int HALF = N_CELLS / 2;

   function automatic logic [N_CELLS-1:0] low_ones(input int k);
      logic [N_CELLS-1:0] v;
      for (int i = 0; i < N_CELLS; i++) begin
         v[i] = (i < k);
      end
      return v;
   endfunction

   localparam logic [N_CELLS-1:0] SEL_RESET = low_ones(HALF);

   logic can_grow;
   logic can_shrink;

   generate
      if (N_CELLS < 2) begin : g_bad_cells
         $error("cs_boundary_reg: N_CELLS must be at least 2");
      end
   endgenerate

   assign can_grow   = ~sel[N_CELLS-2];
   assign can_shrink = sel[1];

   always_ff @(posedge clk) begin
      if (rst) begin
         sel  <= SEL_RESET;
         dir  <= 1'b0;
         stop <= 1'b0;
      end else if (apply) begin
         case (action)
            ACT_GROW: begin
               dir  <= 1'b0;
               stop <= 1'b0;
               if (can_grow) begin
                  sel <= {sel[N_CELLS-2:0], 1'b1};
               end
            end
            ACT_SHRINK: begin
               dir  <= 1'b1;
               stop <= 1'b0;
               if (can_shrink) begin
                  sel <= {1'b0, sel[N_CELLS-1:1]};
               end
            end
            default: begin
               stop <= 1'b1;
            end
         endcase
      end
   end

   // R2: the vector is a run of ones from bit 0
   p_thermo_r2: assert property (@(posedge clk) disable iff (rst)
      (((sel + 1'b1) & sel) == '0));

   // R7: each channel keeps at least one cell
   p_limits_r7: assert property (@(posedge clk) disable iff (rst)
      (sel[0] && !sel[N_CELLS-1]));

   // R2: any change touches exactly one bit
   p_one_step_r2: assert property (@(posedge clk) disable iff (rst)
      !$stable(sel) |-> ($countones(sel ^ $past(sel)) == 1));

   // R4: the vector moves only on the edge that ends a decision cycle
   p_move_on_decide_r4: assert property (@(posedge clk) disable iff (rst)
      !$stable(sel) |-> $past(apply));

   // R3: growth of channel 1 comes with dir low, shrink with dir high
   p_dir_grow_r3: assert property (@(posedge clk) disable iff (rst)
      ($countones(sel) > $countones($past(sel))) |-> !dir);
   p_dir_shrink_r3: assert property (@(posedge clk) disable iff (rst)
      ($countones(sel) < $countones($past(sel))) |-> dir);

   // R5: a stop decision leaves the vector where it was
   p_hold_in_band_r5: assert property (@(posedge clk) disable iff (rst)
      stop |-> $stable(sel));

endmodule

// File: rtl/cell_split_ctrl.sv
module cell_split_ctrl
   import cellsplit_pkg::*;
#(
   parameter int N_CELLS     = 82,
   parameter int WIN_CYCLES  = 1024,
   parameter int EDGE_W      = 10,
   parameter int HYST        = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk_s,
   input  logic               rst,
   input  logic               en,
   input  logic               ch1_clk,
   input  logic               ch2_clk,
   output logic [N_CELLS-1:0] cell_sel,
   output logic               dir,
   output logic               stop,
   output logic               ready
);

   localparam int N_CH = 2;

   logic [N_CH-1:0]   ch_in;
   logic [EDGE_W-1:0] ch_cnt [N_CH];
   logic              meas;
   logic              decide;
   logic              clearing;
   action_t           action;

   assign ch_in = {ch2_clk, ch1_clk};

   generate
      for (genvar c = 0; c < N_CH; c++) begin : g_ch
         cs_edge_counter #(
            .EDGE_W      (EDGE_W),
            .SYNC_STAGES (SYNC_STAGES)
         ) u_cnt (
            .clk      (clk_s),
            .rst      (rst),
            .async_in (ch_in[c]),
            .cnt_en   (meas),
            .clr      (clearing),
            .count    (ch_cnt[c])
         );
      end
   endgenerate

   cs_window_seq #(
      .WIN_CYCLES (WIN_CYCLES)
   ) u_seq (
      .clk      (clk_s),
      .rst      (rst),
      .en       (en),
      .meas     (meas),
      .decide   (decide),
      .clearing (clearing)
   );

   cs_rate_compare #(
      .EDGE_W (EDGE_W),
      .HYST   (HYST)
   ) u_cmp (
      .cnt_a  (ch_cnt[0]),
      .cnt_b  (ch_cnt[1]),
      .action (action)
   );

   cs_boundary_reg #(
      .N_CELLS (N_CELLS)
   ) u_bnd (
      .clk    (clk_s),
      .rst    (rst),
      .apply  (decide),
      .action (action),
      .sel    (cell_sel),
      .dir    (dir),
      .stop   (stop)
   );

   assign ready = decide;

   // R9: enable low suppresses the next decision pulse
   p_no_ready_idle_r9: assert property (@(posedge clk_s) disable iff (rst)
      (!en) |=> !ready);

   // R9: outside a decision cycle the outputs hold
   p_hold_idle_r9: assert property (@(posedge clk_s) disable iff (rst)
      (!ready) |=> ($stable(cell_sel) && $stable(dir) && $stable(stop)));

   // R4: ready is a single-cycle pulse
   p_ready_pulse_r4: assert property (@(posedge clk_s) disable iff (rst)
      ready |=> !ready);

endmodule

// File: tb/sim_cell_split_ctrl.sv
`timescale 1ns/1ps
module sim_cell_split_ctrl;

   localparam int CLK_PERIOD = 10;
   localparam int NA = 16;
   localparam int WA = 720;
   localparam int EA = 8;
   localparam int HA = 4;
   localparam int NB = 8;
   localparam int WB = 64;
   localparam int EB = 4;
   localparam int HB = 1;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic en  = 1'b0;
   logic c1 = 1'b0, c2 = 1'b0, b1 = 1'b0, b2 = 1'b0;

   logic [NA-1:0] sel0;
   logic          dir0, stop0, rdy0;
   logic [NB-1:0] sel1;
   logic          dir1, stop1, rdy1;

   int n_chk = 0;
   int n_bad = 0;
   int mode  = 0;
   int h1    = 20;
   int h2    = 50;

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic int ones16(input logic [NA-1:0] v);
      int k = 0;
      for (int i = 0; i < NA; i++) k += int'(v[i]);
      return k;
   endfunction

   function automatic logic [NA-1:0] therm(input int k);
      logic [NA-1:0] v;
      for (int i = 0; i < NA; i++) v[i] = (i < k);
      return v;
   endfunction

   // channel clocks: fixed half periods, or a load model where more cells slow a channel
   initial begin
      #3;
      forever begin
         if (mode == 1) #(ones16(sel0) * 15) c1 = ~c1;
         else           #(h1) c1 = ~c1;
      end
   end
   initial begin
      #7;
      forever begin
         if (mode == 1) #((NA - ones16(sel0)) * 30) c2 = ~c2;
         else           #(h2) c2 = ~c2;
      end
   end
   initial begin #2; forever #12.5 b1 = ~b1; end
   initial begin #6; forever #20 b2 = ~b2; end

   cell_split_ctrl #(.N_CELLS(NA), .WIN_CYCLES(WA), .EDGE_W(EA), .HYST(HA)) u0 (
      .clk_s(clk), .rst(rst), .en(en), .ch1_clk(c1), .ch2_clk(c2),
      .cell_sel(sel0), .dir(dir0), .stop(stop0), .ready(rdy0));

   cell_split_ctrl #(.N_CELLS(NB), .WIN_CYCLES(WB), .EDGE_W(EB), .HYST(HB)) u1 (
      .clk_s(clk), .rst(rst), .en(en), .ch1_clk(b1), .ch2_clk(b2),
      .cell_sel(sel1), .dir(dir1), .stop(stop1), .ready(rdy1));

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      repeat (3) @(negedge clk);
      rst = 1'b0;
   endtask

   // returns at the negedge after the ready pulse; gap counts negedges until ready was seen
   task automatic wait_dec(output int gap);
      gap = 0;
      @(negedge clk); gap++;
      while (!rdy0) begin @(negedge clk); gap++; end
      @(negedge clk);
   endtask

   task automatic wait_dec_b();
      @(negedge clk);
      while (!rdy1) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic t_reset();
      mode = 0; en = 1'b1;
      rst = 1'b1;
      repeat (3) @(negedge clk);
      check(sel0 == therm(NA/2), "R1 reset sel", 32'(sel0), 32'(therm(NA/2)));
      check(!dir0 && !stop0 && !rdy0, "R1 reset flags", {29'd0, dir0, stop0, rdy0}, 32'd0);
      rst = 1'b0;
      @(negedge clk);
      check(sel0 == therm(NA/2), "R1 sel after release", 32'(sel0), 32'(therm(NA/2)));
   endtask

   task automatic t_grow();
      int gap; int exp_n;
      h1 = 20; h2 = 50; mode = 0; en = 1'b1;
      do_reset();
      exp_n = NA/2;
      for (int d = 0; d < 10; d++) begin
         wait_dec(gap);
         if (d > 0) check(gap == WA + 1, "R4 ready spacing", 32'(gap), 32'(WA + 1));
         check(!rdy0, "R4 ready one cycle", 32'(rdy0), 32'd0);
         exp_n = (exp_n + 1 > NA - 1) ? NA - 1 : exp_n + 1;
         check(sel0 == therm(exp_n), (exp_n == NA - 1) ? "R7 grow saturates" : "R3 grow sel",
               32'(sel0), 32'(therm(exp_n)));
         check(!dir0 && !stop0, "R3 grow dir0 stop0", {30'd0, dir0, stop0}, 32'd0);
      end
   endtask

   task automatic t_shrink();
      int gap; int exp_n;
      h1 = 50; h2 = 20; mode = 0; en = 1'b1;
      do_reset();
      exp_n = NA/2;
      for (int d = 0; d < 9; d++) begin
         wait_dec(gap);
         exp_n = (exp_n - 1 < 1) ? 1 : exp_n - 1;
         check(sel0 == therm(exp_n), (exp_n == 1) ? "R7 shrink saturates" : "R3 shrink sel",
               32'(sel0), 32'(therm(exp_n)));
         check(dir0 && !stop0, "R3 shrink dir1 stop0", {30'd0, dir0, stop0}, 32'd2);
      end
   endtask

   task automatic t_band_resume();
      int gap;
      h1 = 30; h2 = 30; mode = 0; en = 1'b1;
      do_reset();
      for (int d = 0; d < 3; d++) begin
         wait_dec(gap);
         check(sel0 == therm(NA/2), "R5 band holds sel", 32'(sel0), 32'(therm(NA/2)));
         check(stop0 && !dir0, "R5 band stop1 dir held", {30'd0, dir0, stop0}, 32'd1);
      end
      h1 = 50; h2 = 20;
      wait_dec(gap);
      check(sel0 == therm(NA/2 - 1), "R6 resume shift", 32'(sel0), 32'(therm(NA/2 - 1)));
      check(!stop0 && dir0, "R6 resume stop0 dir1", {30'd0, dir0, stop0}, 32'd2);
      h1 = 30; h2 = 30;
      wait_dec(gap);
      wait_dec(gap);
      check(stop0 && sel0 == therm(NA/2 - 1), "R5 stop again", {15'd0, stop0, sel0}, {15'd0, 1'b1, therm(NA/2 - 1)});
   endtask

   task automatic t_converge();
      int gap; int prev; int now; bit seen;
      en = 1'b1; mode = 0;
      do_reset();
      mode = 1;
      seen = 1'b0;
      for (int d = 0; d < 12 && !seen; d++) begin
         prev = ones16(sel0);
         wait_dec(gap);
         now = ones16(sel0);
         check((now - prev <= 1) && (prev - now <= 1), "R2 one cell per decision", 32'(now), 32'(prev));
         if (stop0) seen = 1'b1;
      end
      check(seen, "R5 converged stop", 32'(stop0), 32'd1);
      check(ones16(sel0) >= 10 && ones16(sel0) <= 11, "R6 balance point", 32'(ones16(sel0)), 32'd10);
      for (int d = 0; d < 2; d++) begin
         wait_dec(gap);
         check(ones16(sel0) >= 10 && ones16(sel0) <= 11, "R6 stays balanced", 32'(ones16(sel0)), 32'd10);
      end
      mode = 0;
   endtask

   task automatic t_enable();
      int gap; int pulses;
      h1 = 20; h2 = 50; mode = 0;
      en = 1'b0;
      do_reset();
      pulses = 0;
      for (int i = 0; i < 3 * (WA + 2); i++) begin
         @(negedge clk);
         if (rdy0) pulses++;
      end
      check(pulses == 0, "R9 no ready while disabled", 32'(pulses), 32'd0);
      check(sel0 == therm(NA/2) && !stop0, "R9 outputs held", 32'(sel0), 32'(therm(NA/2)));
      en = 1'b1;
      wait_dec(gap);
      check(gap == WA + 1, "R9 first ready after enable", 32'(gap), 32'(WA + 1));
      check(sel0 == therm(NA/2 + 1) && !dir0, "R9 fresh window decides", 32'(sel0), 32'(therm(NA/2 + 1)));
   endtask

   task automatic t_count_sat();
      en = 1'b1; mode = 0;
      do_reset();
      for (int d = 0; d < 3; d++) wait_dec_b();
      check(sel1 == 8'h0F, "R8 saturated counts hold sel", 32'(sel1), 32'h0F);
      check(stop1 && !dir1, "R8 saturated counts stop", {30'd0, dir1, stop1}, 32'd1);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      t_reset();
      t_grow();
      t_shrink();
      t_band_resume();
      t_converge();
      t_enable();
      t_count_sat();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule